// File: doc/BRIEF.md
# Password-Protected Clock Control Register File

This block is the 32-bit memory-mapped register front end of a clock manager. Software writes configuration words for the PLLs, for the output channels each PLL feeds, and for a set of clock dividers. A write is only taken when the top byte of the written word carries a fixed key. Words that are taken are stored with the key byte zeroed. For one cycle the block then pulses an update strobe toward each piece of clock logic that has to reconfigure. The clock-generating logic is not part of this block.

Reads return the stored words. The one exception is a lock-status word, which is not stored: each time it is read it is built from the power-down and analog-reset bits of the PLL control words. With the defaults there are 4 PLLs, 2 channels per PLL (channel c is fed by PLL c/2) and 3 dividers. Each divider has a control word and a divisor word at adjacent addresses.

Top module: `clkreg_top`

## Requirements
- R1: A write whose bits 31:24 differ from 8'h5A changes no stored word and raises no strobe.
- R2: A write that is taken stores bits 23:0 of the data and stores zero in bits 31:24.
- R3: An access is valid only when bus_addr[1:0] is 0 and bus_be is 4'hF. An invalid write changes nothing and raises no strobe. An invalid read returns zero.
- R4: The lock word is at byte 0x48. Its bit p is 1 exactly when bit 0 (power-down) and bit 1 (analog reset) of PLL p's control word are both 0. Its other bits read 0, and writes to it have no effect.
- R5: A taken write to PLL p's control word (byte 4p) pulses pll_upd_o[p] and chan_upd_o for every channel fed by PLL p.
- R6: A taken write to channel c's word (byte 0x10+4c) pulses chan_upd_o[c] and no other strobe.
- R7: A taken write to divider k's control word (byte 0x30+8k) or divisor word (byte 0x34+8k) pulses div_upd_o[k] and no other strobe.
- R8: Strobes are high for exactly the one cycle after the clock edge that samples the taken write. Back-to-back writes give back-to-back pulses.
- R9: Reset first clears every word and then loads the defaults: 32'h0000_0001 in PLL words, 32'h0000_0100 in channel words, 32'h0000_1000 in divisor words and 0 in divider control words. All strobes are 0 after reset.
- R10: A keyed write to an unmapped address (byte 0x4C and above) has no effect, and a read from such an address returns 0.
- R11: bus_rdata is 0 whenever bus_rd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 8 | Byte address |
| bus_be | input | 4 | Byte enables; all four must be set |
| bus_wr | input | 1 | Write request |
| bus_rd | input | 1 | Read request |
| bus_wdata | input | 32 | Write data with the key in bits 31:24 |
| bus_rdata | output | 32 | Read data, combinational from the address |
| pll_upd_o | output | 4 | One-cycle reconfigure pulse per PLL |
| chan_upd_o | output | 8 | One-cycle reconfigure pulse per channel |
| div_upd_o | output | 3 | One-cycle reconfigure pulse per divider |

## Verification
Read data is combinational and is due in the same cycle as the address. A stored word, and any lock bit that depends on it, changes at the first rising edge after the write is presented, and the strobes are high during the cycle that follows that edge. The reference model steps once at each rising edge, on the inputs that were driven at the preceding falling edge. Both the model's expected values and the design's outputs are sampled 2 ns after each falling edge, so each result is compared in the cycle it is due.

// File: rtl/clkreg_pkg.sv
package clkreg_pkg;
    localparam logic [7:0]  KEY_VALUE     = 8'h5A;
    localparam int          PDN_BIT       = 0;
    localparam int          ARST_BIT      = 1;
    localparam logic [31:0] PLL_RST_WORD  = 32'h0000_0001;
    localparam logic [31:0] CHAN_RST_WORD = 32'h0000_0100;
    localparam logic [31:0] DIVW_RST_WORD = 32'h0000_1000;
    localparam logic [31:0] DCTL_RST_WORD = 32'h0000_0000;
endpackage

// File: rtl/clkreg_decode.sv
module clkreg_decode #(
    parameter int N_PLL      = 4,
    parameter int CH_PER_PLL = 2,
    parameter int N_DIV      = 3,
    parameter int AW         = 8,
    localparam int N_CH      = N_PLL * CH_PER_PLL,
    localparam int CH_BASE   = N_PLL,
    localparam int DIV_BASE  = CH_BASE + N_CH,
    localparam int N_WORDS   = DIV_BASE + 2 * N_DIV,
    localparam int IDX_W     = AW - 2,
    localparam int WIDX_W    = $clog2(N_WORDS)
) (
    input  logic [AW-1:0]     addr,
    input  logic [3:0]        be,
    input  logic              wr,
    input  logic [7:0]        key,
    output logic              aligned,
    output logic              store_en,
    output logic [WIDX_W-1:0] widx,
    output logic [N_PLL-1:0]  pll_hit,
    output logic [N_CH-1:0]   ch_hit,
    output logic [N_DIV-1:0]  div_hit
);
    import clkreg_pkg::*;

    logic [IDX_W-1:0] idx;
    logic             taken;

    always_comb begin
        idx      = addr[AW-1:2];
        aligned  = (addr[1:0] == 2'b00) && (be == 4'hF);
        taken    = wr && aligned && (key == KEY_VALUE);
        store_en = taken && (idx < IDX_W'(N_WORDS));
        widx     = idx[WIDX_W-1:0];
    end

    for (genvar p = 0; p < N_PLL; p++) begin : g_pll
        assign pll_hit[p] = taken && (idx == IDX_W'(p));
    end

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        assign ch_hit[c] = taken && ((idx == IDX_W'(CH_BASE + c)) ||
                                     (idx == IDX_W'(c / CH_PER_PLL)));
    end

    for (genvar k = 0; k < N_DIV; k++) begin : g_div
        assign div_hit[k] = taken && ((idx == IDX_W'(DIV_BASE + 2 * k)) ||
                                      (idx == IDX_W'(DIV_BASE + 2 * k + 1)));
    end
endmodule

// File: rtl/clkreg_store.sv
module clkreg_store #(
    parameter int N_PLL      = 4,
    parameter int CH_PER_PLL = 2,
    parameter int N_DIV      = 3,
    localparam int N_CH      = N_PLL * CH_PER_PLL,
    localparam int CH_BASE   = N_PLL,
    localparam int DIV_BASE  = CH_BASE + N_CH,
    localparam int N_WORDS   = DIV_BASE + 2 * N_DIV,
    localparam int WIDX_W    = $clog2(N_WORDS)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         store_en,
    input  logic [WIDX_W-1:0]            widx,
    input  logic [23:0]                  payload,
    input  logic [N_PLL-1:0]             pll_hit,
    input  logic [N_CH-1:0]              ch_hit,
    input  logic [N_DIV-1:0]             div_hit,
    output logic [N_WORDS-1:0][31:0]     regs,
    output logic [N_PLL-1:0]             pll_upd,
    output logic [N_CH-1:0]              chan_upd,
    output logic [N_DIV-1:0]             div_upd
);
    import clkreg_pkg::*;

    typedef struct packed {
        logic [N_WORDS-1:0][31:0] regs;
        logic [N_PLL-1:0]         pll_upd;
        logic [N_CH-1:0]          chan_upd;
        logic [N_DIV-1:0]         div_upd;
    } state_t;

    // Clear everything, then load the per-word defaults.
    function automatic state_t init_state();
        state_t s;
        s = '0;
        for (int i = 0; i < N_WORDS; i++) begin
            if (i < CH_BASE)                         s.regs[i] = PLL_RST_WORD;
            else if (i < DIV_BASE)                   s.regs[i] = CHAN_RST_WORD;
            else if (((i - DIV_BASE) % 2) == 1)      s.regs[i] = DIVW_RST_WORD;
            else                                     s.regs[i] = DCTL_RST_WORD;
        end
        return s;
    endfunction

    localparam state_t RST_S = init_state();

    state_t s_d, s_q;

    always_comb begin
        s_d          = s_q;
        s_d.pll_upd  = pll_hit;
        s_d.chan_upd = ch_hit;
        s_d.div_upd  = div_hit;
        if (store_en) begin
            s_d.regs[widx] = {8'h00, payload};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= RST_S;
        else        s_q <= s_d;
    end

    assign regs     = s_q.regs;
    assign pll_upd  = s_q.pll_upd;
    assign chan_upd = s_q.chan_upd;
    assign div_upd  = s_q.div_upd;

    AST_DIV_SOLO: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(div_upd)) else $error("divider strobes not one-hot"); // R7

    AST_DIV_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        (|div_upd) |-> (pll_upd == '0 && chan_upd == '0))
        else $error("divider strobe with other strobe"); // R7
endmodule

// File: rtl/clkreg_lock.sv
module clkreg_lock #(
    parameter int N_PLL = 4
) (
    input  logic [N_PLL-1:0][1:0] pll_ctl,
    output logic [N_PLL-1:0]      lock
);
    import clkreg_pkg::*;

    for (genvar p = 0; p < N_PLL; p++) begin : g_lk
        assign lock[p] = !pll_ctl[p][PDN_BIT] && !pll_ctl[p][ARST_BIT];
    end
endmodule

// File: rtl/clkreg_top.sv
module clkreg_top #(
    parameter int N_PLL      = 4,
    parameter int CH_PER_PLL = 2,
    parameter int N_DIV      = 3,
    parameter int AW         = 8,
    localparam int N_CH      = N_PLL * CH_PER_PLL,
    localparam int N_WORDS   = N_PLL + N_CH + 2 * N_DIV,
    localparam int LOCK_IDX  = N_WORDS,
    localparam int IDX_W     = AW - 2,
    localparam int WIDX_W    = $clog2(N_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     bus_addr,
    input  logic [3:0]        bus_be,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [N_PLL-1:0]  pll_upd_o,
    output logic [N_CH-1:0]   chan_upd_o,
    output logic [N_DIV-1:0]  div_upd_o
);
    import clkreg_pkg::*;

    logic                     aligned;
    logic                     store_en;
    logic [WIDX_W-1:0]        widx;
    logic [N_PLL-1:0]         pll_hit;
    logic [N_CH-1:0]          ch_hit;
    logic [N_DIV-1:0]         div_hit;
    logic [N_WORDS-1:0][31:0] regs_w;
    logic [N_PLL-1:0][1:0]    pll_ctl;
    logic [N_PLL-1:0]         lock_w;
    logic [IDX_W-1:0]         ridx;

    clkreg_decode #(.N_PLL(N_PLL), .CH_PER_PLL(CH_PER_PLL), .N_DIV(N_DIV), .AW(AW)) u_dec (
        .addr(bus_addr), .be(bus_be), .wr(bus_wr), .key(bus_wdata[31:24]),
        .aligned(aligned), .store_en(store_en), .widx(widx),
        .pll_hit(pll_hit), .ch_hit(ch_hit), .div_hit(div_hit)
    );

    clkreg_store #(.N_PLL(N_PLL), .CH_PER_PLL(CH_PER_PLL), .N_DIV(N_DIV)) u_store (
        .clk(clk), .rst_n(rst_n), .store_en(store_en), .widx(widx),
        .payload(bus_wdata[23:0]), .pll_hit(pll_hit), .ch_hit(ch_hit),
        .div_hit(div_hit), .regs(regs_w), .pll_upd(pll_upd_o),
        .chan_upd(chan_upd_o), .div_upd(div_upd_o)
    );

    for (genvar p = 0; p < N_PLL; p++) begin : g_ctl
        assign pll_ctl[p] = {regs_w[p][ARST_BIT], regs_w[p][PDN_BIT]};
    end

    clkreg_lock #(.N_PLL(N_PLL)) u_lock (.pll_ctl(pll_ctl), .lock(lock_w));

    always_comb begin
        ridx      = bus_addr[AW-1:2];
        bus_rdata = '0;
        if (bus_rd && aligned) begin
            if (ridx < IDX_W'(N_WORDS))       bus_rdata = regs_w[ridx[WIDX_W-1:0]];
            else if (ridx == IDX_W'(LOCK_IDX)) bus_rdata = 32'(lock_w);
        end
    end

    AST_BAD_KEY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_wdata[31:24] != KEY_VALUE) |=>
        ({pll_upd_o, chan_upd_o, div_upd_o} == '0 && $stable(regs_w)))
        else $error("unkeyed write had an effect"); // R1

    AST_KEY_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && aligned && ridx < IDX_W'(N_WORDS)) |-> (bus_rdata[31:24] == 8'h00))
        else $error("stored word kept key bits"); // R2

    AST_MISALIGN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr[1:0] != 2'b00 || bus_be != 4'hF)) |=>
        ({pll_upd_o, chan_upd_o, div_upd_o} == '0 && $stable(regs_w)))
        else $error("invalid access had an effect"); // R3

    AST_LOCK_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && aligned && ridx == IDX_W'(LOCK_IDX)) |-> (bus_rdata[31:N_PLL] == '0))
        else $error("lock word upper bits set"); // R4

    for (genvar c = 0; c < N_CH; c++) begin : g_fan
        AST_PLL_FANOUT: assert property (@(posedge clk) disable iff (!rst_n)
            pll_upd_o[c / CH_PER_PLL] |-> chan_upd_o[c])
            else $error("PLL strobe missed a channel"); // R5
    end

    AST_PULSE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (|{pll_upd_o, chan_upd_o, div_upd_o}) |-> $past(bus_wr))
        else $error("strobe without preceding write"); // R8

    AST_READ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> (bus_rdata == '0)) else $error("read data without read"); // R11
endmodule

// File: tb/test_clkreg_top.sv
module test_clkreg_top;
    localparam int NPLL = 4;
    localparam int CPP  = 2;
    localparam int NCH  = NPLL * CPP;
    localparam int NDIV = 3;
    localparam int DB   = NPLL + NCH;
    localparam int NW   = DB + 2 * NDIV;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NPLL-1:0] pll_upd_o;
    logic [NCH-1:0]  chan_upd_o;
    logic [NDIV-1:0] div_upd_o;

    int    n_tests = 0;
    int    n_fail  = 0;
    bit    started = 1'b0;
    bit    done    = 1'b0;
    string cur_req = "R9";

    logic [31:0]     m_regs [0:NW-1];
    logic [NPLL-1:0] e_pll;
    logic [NCH-1:0]  e_ch;
    logic [NDIV-1:0] e_div;

    always #4 clk = ~clk;

    clkreg_top i_clkreg_top (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_be(bus_be),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pll_upd_o(pll_upd_o),
        .chan_upd_o(chan_upd_o), .div_upd_o(div_upd_o)
    );

    // Reference model: steps on each rising edge.
    always @(posedge clk) begin
        started = 1'b1;
        e_pll = '0; e_ch = '0; e_div = '0;
        if (!rst_n) begin
            for (int i = 0; i < NW; i++) begin
                if (i < NPLL)                 m_regs[i] = 32'h0000_0001;
                else if (i < DB)              m_regs[i] = 32'h0000_0100;
                else if ((i - DB) % 2 == 1)   m_regs[i] = 32'h0000_1000;
                else                          m_regs[i] = 32'h0;
            end
        end else if (bus_wr && bus_be == 4'hF && bus_addr[1:0] == 2'b00 &&
                     bus_wdata[31:24] == 8'h5A) begin
            int w;
            w = int'(bus_addr) / 4;
            if (w < NW) m_regs[w] = bus_wdata & 32'h00FF_FFFF;
            if (w < NPLL) begin
                e_pll[w] = 1'b1;
                for (int c = 0; c < NCH; c++) if (c / CPP == w) e_ch[c] = 1'b1;
            end else if (w < DB) begin
                e_ch[w - NPLL] = 1'b1;
            end else if (w < NW) begin
                e_div[(w - DB) / 2] = 1'b1;
            end
        end
    end

    function automatic logic [31:0] exp_rdata();
        int w;
        logic [31:0] r;
        r = '0;
        w = int'(bus_addr) / 4;
        if (bus_rd && bus_be == 4'hF && bus_addr[1:0] == 2'b00) begin
            if (w < NW) r = m_regs[w];
            else if (w == NW)
                for (int p = 0; p < NPLL; p++) r[p] = !m_regs[p][0] && !m_regs[p][1];
        end
        return r;
    endfunction

    // Compare away from the active edge.
    always @(negedge clk) begin
        if (started && !done) begin
            #2;
            n_tests += 4;
            if (bus_rdata !== exp_rdata()) begin
                n_fail++;
                $display("FAIL %s rdata addr %h: actual %h expected %h", cur_req, bus_addr, bus_rdata, exp_rdata());
            end
            if (pll_upd_o !== e_pll) begin
                n_fail++;
                $display("FAIL R5 (%s) pll strobes: actual %b expected %b", cur_req, pll_upd_o, e_pll);
            end
            if (chan_upd_o !== e_ch) begin
                n_fail++;
                $display("FAIL R6 (%s) channel strobes: actual %b expected %b", cur_req, chan_upd_o, e_ch);
            end
            if (div_upd_o !== e_div) begin
                n_fail++;
                $display("FAIL R7 (%s) divider strobes: actual %b expected %b", cur_req, div_upd_o, e_div);
            end
        end
    end

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_be = be; bus_wr = 1'b1; bus_rd = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, input logic [3:0] be = 4'hF);
        @(negedge clk);
        bus_addr = a; bus_be = be; bus_wr = 1'b0; bus_rd = 1'b1; bus_wdata = '0;
    endtask

    task automatic bus_idle(input logic [7:0] a = 8'h00);
        @(negedge clk);
        bus_addr = a; bus_be = 4'hF; bus_wr = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic read_all();
        for (int w = 0; w <= NW; w++) bus_read(8'(4 * w));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        cur_req = "R9";
        read_all();
        bus_read(8'hFC);

        cur_req = "R2";
        bus_write(8'h00, 32'h5A12_3456);
        bus_write(8'h04, 32'h5AFF_FFFC);
        bus_write(8'h08, 32'h5A00_0002);
        bus_write(8'h0C, 32'h5A00_0000);
        bus_idle();
        read_all();

        cur_req = "R1";
        bus_write(8'h04, 32'hA500_0003);
        bus_write(8'h00, 32'h5B00_0000);
        bus_write(8'h40, 32'h0000_0001);
        bus_idle();
        bus_read(8'h00); bus_read(8'h04); bus_read(8'h40); bus_read(8'h48);

        cur_req = "R3";
        bus_write(8'h05, 32'h5A00_0003);
        bus_write(8'h04, 32'h5A00_0003, 4'h7);
        bus_write(8'h32, 32'h5A00_0077);
        bus_idle();
        bus_read(8'h05); bus_read(8'h04, 4'h3); bus_read(8'h04); bus_read(8'h30);

        cur_req = "R6";
        for (int c = 0; c < NCH; c++) bus_write(8'(8'h10 + 4 * c), 32'h5A00_0000 | (c * 32'h111));
        bus_idle();
        for (int c = 0; c < NCH; c++) bus_read(8'(8'h10 + 4 * c));

        cur_req = "R7";
        for (int k = 0; k < NDIV; k++) begin
            bus_write(8'(8'h30 + 8 * k), 32'h5A00_0010 + k);
            bus_idle();
            bus_write(8'(8'h34 + 8 * k), 32'h5A00_2800 + k);
            bus_idle();
        end
        for (int k = 0; k < 2 * NDIV; k++) bus_read(8'(8'h30 + 4 * k));

        cur_req = "R4";
        bus_write(8'h48, 32'h5A00_00FF);
        bus_read(8'h48);
        bus_write(8'h00, 32'h5A00_0000);
        bus_read(8'h48);
        bus_write(8'h04, 32'h5A00_0001);
        bus_read(8'h48);
        bus_write(8'h0C, 32'h5A00_0003);
        bus_read(8'h48);

        cur_req = "R10";
        bus_write(8'h4C, 32'h5AAB_CDEF);
        bus_write(8'hFC, 32'h5A12_3456);
        bus_idle();
        bus_read(8'h4C); bus_read(8'hFC);
        read_all();

        cur_req = "R11";
        bus_idle(8'h04);
        bus_idle(8'h48);
        bus_idle(8'h34);

        cur_req = "R8";
        bus_write(8'h00, 32'h5A00_0100);
        bus_write(8'h08, 32'h5A00_0200);
        bus_write(8'h1C, 32'h5A00_0300);
        bus_write(8'h44, 32'h5A00_0400);
        bus_idle(); bus_idle();
        read_all();

        bus_idle();
        @(negedge clk);
        #3;
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL R8 watchdog expired: actual running expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule